// File: doc/BRIEF.md
# Asynchronous Serial Channel with Address/Data Flag Bit

This block is one transmit and receive channel of an asynchronous serial port. In addition to plain 8-bit frames it supports a multi-drop format: one extra flag bit is inserted between the last data bit and the stop bit. On a shared line this flag marks each frame as an address (1) or as data (0). Software controls the channel through a small register bus. That bus gives access to a transmit holding byte, a received byte, a control register and a status register. The status register carries four flags: holding register empty, transmission finished, last received flag bit, and receive byte available. A second write path lets a hardware transfer agent refill the holding byte whenever the channel requests it.

The channel does not divide the clock itself. An external baud tick advances both directions, and every bit lasts 16 ticks. A frame has one low start bit, eight data bits sent least significant bit first, the flag bit when the multi-drop format is on, and one high stop bit. The line idles high. The receiver synchronises its input, finds the falling edge of the start bit, and samples each bit on its 8th tick.

The refill port is a valid/ready stream. `fill_ready` is high only while the transmitter is enabled and the holding byte is empty. A transfer happens on a clock edge where `fill_valid` and `fill_ready` are both high. The source must hold `fill_data` stable while it waits and may not drop a byte that has been offered.

Top module: `uart_mp_chan`

## Requirements
- R1: After reset the status register (address 1) reads 0x03, meaning bit 0 (holding empty) is 1, bit 1 (transmission finished) is 1, bit 2 (received flag bit) is 0 and bit 3 (byte available) is 0. The control register (address 3) reads 0, and `txd` is 1.
- R2: A transmitted frame is a 0 start bit, then data bits 0 through 7, then the flag bit when control bit 2 is set, then a 1 stop bit. Each bit lasts 16 baud ticks, and the line is 1 when no frame is being sent.
- R3: Holding empty (status bit 0) is cleared by a bus write with bit 0 = 0 to address 1 only if a status read has returned bit 0 = 1 since the last clear. Without such a read, the write leaves the flag at 1.
- R4: Holding empty is set again when the shift register takes the byte written at address 0. If the flag is 0 when a stop bit ends, the next frame starts without any idle bit between the two frames.
- R5: While control bit 0 (transmit enable) is 0, transmission finished reads 1 and `txd` is 1. A frame that is in progress is abandoned.
- R6: Transmission finished becomes 1 at the end of a stop bit only if holding empty is 1 at that moment. It stays 0 while a queued byte follows.
- R7: Transmission finished is cleared together with holding empty, either by a software clear or by a refill transfer. Bus writes to status bit 1 do not change it.
- R8: When control bit 2 is 0, control bit 3 (outgoing flag value) has no effect and frames are 10 bits long. When control bit 2 is 1, the flag bit carries the value of control bit 3 that was present when the shift register took the byte.
- R9: With control bit 1 (receive enable) set, a frame whose stop bit samples 1 is stored at address 2 and sets status bit 3. A bus read of address 2 clears status bit 3.
- R10: The received flag bit (status bit 2) takes the flag bit of every frame received in the multi-drop format, 0 or 1. It keeps its value while receive enable is 0 and when the format is off.
- R11: `fill_ready` equals transmit enable AND holding empty. An accepted refill loads the holding byte and clears holding empty and transmission finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One pulse per 1/16 of a bit |
| bus_addr | input | 2 | Register address: 0 tx byte, 1 status, 2 rx byte, 3 control |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; read side effects occur at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| fill_valid | input | 1 | Refill agent offers a byte |
| fill_data | input | 8 | Refill byte |
| fill_ready | output | 1 | Channel requests a byte |

## Verification
Most wrong internal states in this block become visible at the ports within one frame time, which is 160 or 176 clock cycles when the tick runs every clock. A stuck or mistimed empty or finished flag shows up on the next status read. A clear rule that fires too easily shows up as a frame on `txd` that software never released. A frame length or bit order fault corrupts the byte that comes back through the loopback, and does so within one stop bit. A received flag bit that is held wrongly only shows once a frame arrives while receive is disabled or while the format is off. For that reason the bench drives frames in exactly those conditions and reads the flag back afterwards.

// File: rtl/uart_mp_pkg.sv
package uart_mp_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_TBYTE = 2'd0,
    A_STAT  = 2'd1,
    A_RBYTE = 2'd2,
    A_CTRL  = 2'd3
  } reg_addr_e;

  localparam int ST_HEMPTY = 0;
  localparam int ST_TDONE  = 1;
  localparam int ST_RFLAG  = 2;
  localparam int ST_RAVAIL = 3;

  typedef struct packed {
    logic flag_val;
    logic mp_en;
    logic rx_en;
    logic tx_en;
  } ctrl_t;
endpackage

// File: rtl/uart_mp_sync.sv
module uart_mp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[i] <= RST_VAL;
        else if (i == 0) q[i] <= din;
        else q[i] <= q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign dout = q[STAGES-1];
endmodule

// File: rtl/uart_mp_tx.sv
module uart_mp_tx #(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic              mp_en,
  input  logic              flag_in,
  input  logic              have_data,
  input  logic [DATA_W-1:0] data_in,
  output logic              take,
  output logic              done,
  output logic              busy,
  output logic              txd
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(OVERSAMPLE);
  localparam int IDX_W   = $clog2(FRAME_W + 1);

  logic               busy_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [IDX_W-1:0]   idx_q;
  logic [IDX_W-1:0]   last_q;
  logic [FRAME_W-1:0] shreg_q;
  logic [FRAME_W-1:0] frame;
  logic               bit_end;

  // Frame bits in send order from bit 0; the spare top bit is a stop level.
  assign frame   = mp_en ? {1'b1, flag_in, data_in, 1'b0}
                         : {2'b11, data_in, 1'b0};
  assign bit_end = busy_q && tick && (cnt_q == CNT_W'(OVERSAMPLE - 1));
  assign done    = enable && bit_end && (idx_q == last_q);
  assign take    = enable && have_data && (!busy_q || done);
  assign busy    = busy_q;
  assign txd     = busy_q ? shreg_q[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      shreg_q <= '1;
    end else if (!enable) begin
      busy_q  <= 1'b0;
    end else if (take) begin
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      idx_q   <= '0;
      last_q  <= IDX_W'(mp_en ? FRAME_W - 1 : FRAME_W - 2);
      shreg_q <= frame;
    end else if (done) begin
      busy_q  <= 1'b0;
    end else if (bit_end) begin
      cnt_q   <= '0;
      idx_q   <= idx_q + IDX_W'(1);
      shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
    end else if (busy_q && tick) begin
      cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

  // R2: a loaded frame always begins with the low start bit.
  p_start_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (busy_q && !txd));

  // R4: once a frame has been taken, the line is held for at least one full tick period.
  p_no_early_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !done);
endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx #(
  parameter int DATA_W      = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic              mp_en,
  input  logic              rxd,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              flag
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(DATA_W + 4);
  localparam int MID   = OVERSAMPLE / 2 - 1;

  logic              rx_s;
  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              flag_q;
  logic [IDX_W-1:0]  last_idx;
  logic              sample;

  uart_mp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (rx_s)
  );

  assign last_idx = IDX_W'(mp_en ? DATA_W + 2 : DATA_W + 1);
  assign sample   = active_q && tick && (cnt_q == CNT_W'(MID));
  assign done     = enable && sample && (idx_q == last_idx) && rx_s;
  assign data     = shreg_q;
  assign flag     = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      idx_q    <= '0;
      shreg_q  <= '0;
      flag_q   <= 1'b0;
    end else if (!enable) begin
      active_q <= 1'b0;
    end else if (!active_q) begin
      if (!rx_s) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        idx_q    <= '0;
      end
    end else if (tick) begin
      if (cnt_q == CNT_W'(OVERSAMPLE - 1)) begin
        cnt_q <= '0;
        idx_q <= idx_q + IDX_W'(1);
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
      if (cnt_q == CNT_W'(MID)) begin
        if (idx_q == '0) begin
          if (rx_s) active_q <= 1'b0;
        end else if (idx_q <= IDX_W'(DATA_W)) begin
          shreg_q <= {rx_s, shreg_q[DATA_W-1:1]};
        end else if (idx_q == last_idx) begin
          active_q <= 1'b0;
        end else begin
          flag_q <= rx_s;
        end
      end
    end
  end

  // R9: disabling the receiver abandons any frame in progress.
  p_abort_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !active_q);
endmodule

// File: rtl/uart_mp_chan.sv
module uart_mp_chan
  import uart_mp_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rxd,
  output logic              txd,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  output logic              fill_ready
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] tbyte_q, rbyte_q;
  logic              hempty_q, tdone_q, seen_q, ravail_q, rflag_q;
  logic              tx_take, tx_done, tx_busy;
  logic              rx_done, rx_flag;
  logic [DATA_W-1:0] rx_data;
  logic              wr_tbyte, wr_stat, wr_ctrl, rd_stat, rd_rbyte;
  logic              sw_clear, fill_fire, any_clear;

  assign wr_tbyte  = bus_wr && (bus_addr == A_TBYTE);
  assign wr_stat   = bus_wr && (bus_addr == A_STAT);
  assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
  assign rd_stat   = bus_rd && (bus_addr == A_STAT);
  assign rd_rbyte  = bus_rd && (bus_addr == A_RBYTE);
  assign sw_clear  = wr_stat && !bus_wdata[ST_HEMPTY] && seen_q && hempty_q;
  assign fill_ready = ctrl_q.tx_en && hempty_q;
  assign fill_fire = fill_valid && fill_ready;
  assign any_clear = sw_clear || fill_fire;

  uart_mp_tx #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (baud_tick),
    .enable   (ctrl_q.tx_en),
    .mp_en    (ctrl_q.mp_en),
    .flag_in  (ctrl_q.flag_val),
    .have_data(!hempty_q),
    .data_in  (tbyte_q),
    .take     (tx_take),
    .done     (tx_done),
    .busy     (tx_busy),
    .txd      (txd)
  );

  uart_mp_rx #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (baud_tick),
    .enable(ctrl_q.rx_en),
    .mp_en (ctrl_q.mp_en),
    .rxd   (rxd),
    .done  (rx_done),
    .data  (rx_data),
    .flag  (rx_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      tbyte_q  <= '0;
      rbyte_q  <= '0;
      hempty_q <= 1'b1;
      tdone_q  <= 1'b1;
      seen_q   <= 1'b0;
      ravail_q <= 1'b0;
      rflag_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[3:0]);

      if (fill_fire)     tbyte_q <= fill_data;
      else if (wr_tbyte) tbyte_q <= bus_wdata;

      if (tx_take)        hempty_q <= 1'b1;
      else if (any_clear) hempty_q <= 1'b0;

      if (any_clear)                seen_q <= 1'b0;
      else if (rd_stat && hempty_q) seen_q <= 1'b1;

      if (!ctrl_q.tx_en)             tdone_q <= 1'b1;
      else if (any_clear)            tdone_q <= 1'b0;
      else if (tx_done && hempty_q)  tdone_q <= 1'b1;

      if (rx_done) begin
        rbyte_q  <= rx_data;
        ravail_q <= 1'b1;
        if (ctrl_q.mp_en) rflag_q <= rx_flag;
      end else if (rd_rbyte) begin
        ravail_q <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_TBYTE: bus_rdata = tbyte_q;
      A_STAT:  bus_rdata = {4'b0, ravail_q, rflag_q, tdone_q, hempty_q};
      A_RBYTE: bus_rdata = rbyte_q;
      default: bus_rdata = {4'b0, ctrl_q};
    endcase
  end

  // R5: a disabled transmitter reports finished and drives the line high.
  p_done_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.tx_en |=> (tdone_q && txd));

  // R4: the empty flag only returns when the shift register has taken the byte.
  p_empty_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hempty_q) |-> $past(tx_take));

  // R6: finished only rises at a stop-bit end or with the transmitter off.
  p_done_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tdone_q) |-> ($past(tx_done) || !$past(ctrl_q.tx_en)));

  // R11: an accepted refill leaves both transmit flags low.
  p_fill_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready && ctrl_q.tx_en) |=> (!hempty_q || tx_busy) && !tdone_q);

  // R9: the available flag rises only on a completed frame.
  p_avail_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ravail_q) |-> $past(rx_done));

  // R10: with the receiver off the received flag bit is held.
  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.rx_en |=> $stable(rflag_q));
endmodule

// File: tb/sim_uart_mp_chan.sv
module sim_uart_mp_chan;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {mp_en, flag_val, data}
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 8'hA5}, {1'b1, 1'b0, 8'h3C}, {1'b0, 1'b1, 8'hFF},
    {1'b1, 1'b1, 8'h00}, {1'b0, 1'b0, 8'h81}, {1'b1, 1'b0, 8'h7E}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       txd, fill_valid = 1'b0, fill_ready;
  logic [7:0] fill_data = '0;
  int         n_tests = 0, n_fail = 0;
  logic       flag_model = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_mp_chan u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(txd), .txd(txd),
    .fill_valid(fill_valid), .fill_data(fill_data), .fill_ready(fill_ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    logic [7:0] s;
    bus_write(2'd0, d);
    bus_read(2'd1, s);
    bus_write(2'd1, 8'h00);
  endtask

  task automatic wait_rx(input string req, output logic [7:0] d);
    logic [7:0] s = '0;
    for (int i = 0; i < 400 && !s[3]; i++) bus_read(2'd1, s);
    check(req, {31'b0, s[3]}, 32'd1);
    bus_read(2'd2, d);
  endtask

  task automatic wait_tdone;
    logic [7:0] s = '0;
    for (int i = 0; i < 400 && !s[1]; i++) bus_read(2'd1, s);
  endtask

  task automatic capture(input int nbits, output logic [10:0] v);
    v = '1;
    for (int i = 0; i < 100 && txd; i++) @(negedge clk);
    repeat (8) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      v[b] = txd;
      if (b != nbits - 1) repeat (16) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    logic [10:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3: clear attempt without a prior read of the empty flag.
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, s);
    check("R1/R3 status after reset and unread clear", s, 8'h03);
    bus_read(2'd3, s);
    check("R1 control reset", s, 8'h00);
    check("R1 txd idle", txd, 1'b1);
    check("R11 fill_ready low with tx off", fill_ready, 1'b0);

    // Table of frames through the loopback.
    for (int k = 0; k < NVEC; k++) begin
      bus_write(2'd3, {4'b0, VEC[k][8], VEC[k][9], 2'b11});
      send_byte(VEC[k][7:0]);
      wait_rx("R9 byte arrives", d);
      check("R2/R9 loopback byte", d, VEC[k][7:0]);
      if (VEC[k][9]) flag_model = VEC[k][8];
      bus_read(2'd1, s);
      check("R10 received flag bit", s[2], flag_model);
      check("R9 avail cleared by read", s[3], 1'b0);
      wait_tdone;
    end

    // R2: exact waveform of a multi-drop frame.
    bus_write(2'd3, 8'h0F);
    send_byte(8'hA5);
    capture(11, v);
    check("R2 frame bits with flag", v, {1'b1, 1'b1, 8'hA5, 1'b0});
    wait_rx("R9 byte arrives", d);
    wait_tdone;

    // R8: flag value 0 with the format off must not add a bit.
    bus_write(2'd3, 8'h03);
    send_byte(8'h00);
    capture(10, v);
    check("R8 ten-bit frame, bit 9 is stop", v[9:0], {1'b1, 8'h00, 1'b0});
    wait_rx("R9 byte arrives", d);
    check("R8 byte", d, 8'h00);
    bus_read(2'd1, s);
    check("R8/R10 flag unchanged with format off", s[2], 1'b1);
    wait_tdone;

    // R6/R7: single byte; finished low during frame, write to bit 1 ignored.
    bus_write(2'd3, 8'h03);
    send_byte(8'h5A);
    bus_write(2'd1, 8'h02);
    bus_read(2'd1, s);
    check("R7 finished not writable", s[1], 1'b0);
    wait_rx("R9 byte arrives", d);
    repeat (20) @(negedge clk);
    bus_read(2'd1, s);
    check("R6 finished after lone frame", s[1], 1'b1);

    // R4/R6: back-to-back frames.
    send_byte(8'h11);
    repeat (4) @(negedge clk);
    bus_read(2'd1, s);
    check("R4 empty set after take", s[0], 1'b1);
    send_byte(8'h22);
    wait_rx("R9 first of pair", d);
    check("R4 first byte", d, 8'h11);
    repeat (20) @(negedge clk);
    bus_read(2'd1, s);
    check("R6 finished stays low with queued byte", s[1], 1'b0);
    wait_rx("R4 second of pair", d);
    check("R4 second byte", d, 8'h22);
    wait_tdone;

    // R10: receiver off keeps the flag bit.
    bus_write(2'd3, 8'h0F);
    send_byte(8'h44);
    wait_rx("R10 flag frame", d);
    wait_tdone;
    bus_write(2'd3, 8'h05);
    send_byte(8'h99);
    wait_tdone;
    bus_read(2'd1, s);
    check("R10 flag held with rx off", s[2], 1'b1);
    check("R9 nothing stored with rx off", s[3], 1'b0);

    // R5: transmitter disabled in mid frame.
    bus_write(2'd3, 8'h01);
    send_byte(8'h55);
    repeat (40) @(negedge clk);
    bus_read(2'd1, s);
    check("R7 finished low in frame", s[1], 1'b0);
    bus_write(2'd3, 8'h00);
    bus_read(2'd1, s);
    check("R5 finished forced with tx off", s[1], 1'b1);
    check("R5 line high with tx off", txd, 1'b1);

    // R11: refill port.
    bus_write(2'd3, 8'h03);
    bus_read(2'd2, d);
    check("R11 fill_ready high when empty", fill_ready, 1'b1);
    @(negedge clk); fill_data = 8'hC3; fill_valid = 1'b1;
    @(negedge clk); fill_valid = 1'b0;
    bus_read(2'd1, s);
    check("R11 finished cleared by refill", s[1], 1'b0);
    wait_rx("R11 refill byte arrives", d);
    check("R11 refill byte", d, 8'hC3);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule